// File: doc/BRIEF.md
# Auto-Range Gain Controller

This controller chooses the gain range for a programmable front end by watching the samples it produces. Each sample arrives as an unsigned magnitude with a valid strobe and a flag that marks clipping or a near-rail output. The controller compares each usable sample against an upper and a lower threshold that belong to the current range. It then either holds the range or moves it by exactly one position. Range 0 is the least gain and the highest index is the most gain.

Every move is guarded. After a switch, a configurable number of samples is tagged unusable while the analog path settles, and no decision is taken from them. A second count sets how many samples must pass in the new range before an ordinary move is allowed again. A clip is the one exception: it forces a downshift at once. The two directions are deliberately unequal. Too much signal moves the range down on a single sample, while too little signal needs a run of consecutive quiet samples. The stable flag rises only when a usable sample after the switch falls inside the window.

Top module: `arc_top`

## Requirements
- R1: While reset is held and after its release, `gain_idx` is 0 (lowest gain), and `gain_chg` and `range_stable` are 0.
- R2: `smp_ok` is 1 exactly when `smp_valid` is 1 and the blanking count is exhausted. After every range change, the next `blank_len` strobed samples get `smp_ok`=0 and influence no decision, stable flag or counter other than dwell.
- R3: The index moves by exactly one position per change. `gain_chg` is high for the single clock that follows the deciding sample's edge, and `gain_idx` already holds the new value in that clock.
- R4: A usable sample with `smp_clip`=1 while `gain_idx`>0 lowers the index by one on that sample, whatever the dwell count.
- R5: A usable sample whose magnitude exceeds the current range's upper threshold, without a clip, lowers the index only if at least `dwell_len` strobed samples have been seen since the last change.
- R6: The index rises by one when `run_len` consecutive usable samples lie below the current range's lower threshold, the dwell count is satisfied, and the index is below its maximum. A `run_len` of 0 acts as 1.
- R7: The two directions are asymmetric. One over-threshold sample is enough to move down, but a single quiet sample does not move up when `run_len`>1. An in-window, over-threshold or clipped usable sample restarts the quiet run.
- R8: The index saturates. A clip or over-threshold sample at index 0 causes no change, and quiet samples at index 7 cause no change.
- R9: `range_stable` is cleared on every change. It is set by the first later usable sample that has no clip and a magnitude in [lower, upper] of the current range. Otherwise it keeps its value.
- R10: The thresholds of range r sit at bits [r*16 +: 16] of `thr_hi` and `thr_lo`, and only the current range's pair is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_mag | input | 16 | Sample magnitude |
| smp_clip | input | 1 | Clip or near-rail flag for this sample |
| thr_hi | input | 128 | Upper thresholds, one 16-bit field per range |
| thr_lo | input | 128 | Lower thresholds, one 16-bit field per range |
| dwell_len | input | 8 | Minimum samples in a range before a non-clip change |
| blank_len | input | 8 | Samples tagged unusable after a change |
| run_len | input | 8 | Consecutive quiet samples needed to upshift |
| gain_idx | output | 3 | Requested gain range |
| gain_chg | output | 1 | One-clock pulse on a range change |
| range_stable | output | 1 | Range confirmed by an in-window sample |
| smp_ok | output | 1 | Current sample is usable |

## Verification
The table-driven run feeds several kinds of sample. In-window samples set the stable flag and break quiet runs. Runs of quiet samples separate run counting from the dwell gate. Over-threshold samples arriving before and after the dwell count tell the dwell lockout apart from the plain comparison. Clipped samples during dwell show the override, and clipped samples during blanking show that blanked data is ignored. In one case a magnitude lies between the thresholds of two neighbouring ranges, which shows whether the comparator reads the current range's field. Directed runs then change the counts to drive the index into both ends and to hold an upshift behind a long dwell.

// File: rtl/arc_pkg.sv
package arc_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

endpackage

// File: rtl/arc_window.sv
module arc_window #(
  parameter int MAG_W      = 16,
  parameter int NUM_RANGES = 8,
  localparam int IDX_W     = $clog2(NUM_RANGES)
) (
  input  logic [IDX_W-1:0]            cur_idx,
  input  logic [MAG_W-1:0]            mag,
  input  logic                        clip,
  input  logic [NUM_RANGES*MAG_W-1:0] thr_hi,
  input  logic [NUM_RANGES*MAG_W-1:0] thr_lo,
  output logic                        is_above,
  output logic                        is_below,
  output logic                        in_win
);

  logic [MAG_W-1:0] hi_tab [NUM_RANGES];
  logic [MAG_W-1:0] lo_tab [NUM_RANGES];
  logic [MAG_W-1:0] hi_sel;
  logic [MAG_W-1:0] lo_sel;

  for (genvar r = 0; r < NUM_RANGES; r++) begin : g_unpack
    assign hi_tab[r] = thr_hi[r*MAG_W +: MAG_W];
    assign lo_tab[r] = thr_lo[r*MAG_W +: MAG_W];
  end

  always_comb begin
    hi_sel   = hi_tab[cur_idx];
    lo_sel   = lo_tab[cur_idx];
    is_above = (mag > hi_sel);
    is_below = (mag < lo_sel) && !clip;
    in_win   = !clip && !is_above && (mag >= lo_sel);
  end

endmodule

// File: rtl/arc_guard.sv
module arc_guard #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic             restart,
  input  logic [CNT_W-1:0] blank_len,
  input  logic [CNT_W-1:0] dwell_len,
  output logic             usable,
  output logic             dwell_done
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] blank_q, blank_d;
  logic [CNT_W-1:0] dwell_q, dwell_d;
  logic             cnt_en;

  assign usable     = smp_valid && (blank_q == '0);
  assign dwell_done = (dwell_q >= dwell_len);
  assign cnt_en     = smp_valid || restart;

  always_comb begin
    blank_d = blank_q;
    dwell_d = dwell_q;
    if (restart) begin
      blank_d = blank_len;
      dwell_d = '0;
    end else if (smp_valid) begin
      if (blank_q != '0) blank_d = blank_q - 1'b1;
      if (dwell_q != CNT_MAX) dwell_d = dwell_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q <= '0;
      dwell_q <= '0;
    end else if (cnt_en) begin
      blank_q <= blank_d;
      dwell_q <= dwell_d;
    end
  end

  AST_BLANK_NO_USE: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (blank_q != '0)) |-> !usable); // R2

  AST_DWELL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (dwell_q == '0)); // R5

endmodule

// File: rtl/arc_step.sv
module arc_step
  import arc_pkg::*;
#(
  parameter int NUM_RANGES = 8,
  parameter int CNT_W      = 8,
  localparam int IDX_W     = $clog2(NUM_RANGES),
  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(NUM_RANGES - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             usable,
  input  logic             clip,
  input  logic             is_above,
  input  logic             is_below,
  input  logic             in_win,
  input  logic             dwell_done,
  input  logic [CNT_W-1:0] run_len,
  output step_e            step,
  output logic [IDX_W-1:0] gain_idx,
  output logic             gain_chg,
  output logic             range_stable
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] quiet_q, quiet_d;
  logic             chg_q, chg_d;
  logic             stab_q, stab_d;
  logic [CNT_W-1:0] run_eff;
  logic             run_hit;
  logic             at_bot, at_top;

  assign at_bot  = (idx_q == '0);
  assign at_top  = (idx_q == MAX_IDX);
  assign run_eff = (run_len == '0) ? CNT_W'(1) : run_len;
  assign run_hit = ({1'b0, quiet_q} + 1'b1) >= {1'b0, run_eff};

  always_comb begin
    step = STEP_HOLD;
    if (usable) begin
      if (clip && !at_bot)
        step = STEP_DOWN;
      else if (is_above && dwell_done && !at_bot)
        step = STEP_DOWN;
      else if (is_below && run_hit && dwell_done && !at_top)
        step = STEP_UP;
    end
  end

  always_comb begin
    idx_d   = idx_q;
    quiet_d = quiet_q;
    stab_d  = stab_q;
    chg_d   = (step != STEP_HOLD);
    unique case (step)
      STEP_UP: begin
        idx_d   = idx_q + 1'b1;
        quiet_d = '0;
        stab_d  = 1'b0;
      end
      STEP_DOWN: begin
        idx_d   = idx_q - 1'b1;
        quiet_d = '0;
        stab_d  = 1'b0;
      end
      default: begin
        if (usable) begin
          if (is_below) begin
            if (quiet_q != CNT_MAX) quiet_d = quiet_q + 1'b1;
          end else begin
            quiet_d = '0;
          end
          if (in_win) stab_d = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      quiet_q <= '0;
      chg_q   <= 1'b0;
      stab_q  <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      quiet_q <= quiet_d;
      chg_q   <= chg_d;
      stab_q  <= stab_d;
    end
  end

  assign gain_idx     = idx_q;
  assign gain_chg     = chg_q;
  assign range_stable = stab_q;

  AST_CLIP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (usable && clip && (idx_q != '0)) |=> (idx_q == $past(idx_q) - 1'b1)); // R4

  AST_TOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (at_top && !(usable && (clip || is_above))) |=> (idx_q == MAX_IDX)); // R8

endmodule

// File: rtl/arc_top.sv
module arc_top
  import arc_pkg::*;
#(
  parameter int MAG_W      = 16,
  parameter int NUM_RANGES = 8,
  parameter int CNT_W      = 8,
  localparam int IDX_W     = $clog2(NUM_RANGES),
  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(NUM_RANGES - 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        smp_valid,
  input  logic [MAG_W-1:0]            smp_mag,
  input  logic                        smp_clip,
  input  logic [NUM_RANGES*MAG_W-1:0] thr_hi,
  input  logic [NUM_RANGES*MAG_W-1:0] thr_lo,
  input  logic [CNT_W-1:0]            dwell_len,
  input  logic [CNT_W-1:0]            blank_len,
  input  logic [CNT_W-1:0]            run_len,
  output logic [IDX_W-1:0]            gain_idx,
  output logic                        gain_chg,
  output logic                        range_stable,
  output logic                        smp_ok
);

  logic  rst_s1, rst_s2;
  logic  is_above, is_below, in_win;
  logic  usable, dwell_done;
  step_e step;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  arc_window #(
    .MAG_W      (MAG_W),
    .NUM_RANGES (NUM_RANGES)
  ) u_window (
    .cur_idx  (gain_idx),
    .mag      (smp_mag),
    .clip     (smp_clip),
    .thr_hi   (thr_hi),
    .thr_lo   (thr_lo),
    .is_above (is_above),
    .is_below (is_below),
    .in_win   (in_win)
  );

  arc_guard #(
    .CNT_W (CNT_W)
  ) u_guard (
    .clk        (clk),
    .rst_n      (rst_s2),
    .smp_valid  (smp_valid),
    .restart    (step != STEP_HOLD),
    .blank_len  (blank_len),
    .dwell_len  (dwell_len),
    .usable     (usable),
    .dwell_done (dwell_done)
  );

  arc_step #(
    .NUM_RANGES (NUM_RANGES),
    .CNT_W      (CNT_W)
  ) u_step (
    .clk          (clk),
    .rst_n        (rst_s2),
    .usable       (usable),
    .clip         (smp_clip),
    .is_above     (is_above),
    .is_below     (is_below),
    .in_win       (in_win),
    .dwell_done   (dwell_done),
    .run_len      (run_len),
    .step         (step),
    .gain_idx     (gain_idx),
    .gain_chg     (gain_chg),
    .range_stable (range_stable)
  );

  assign smp_ok = usable;

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_s2)
    (gain_idx != $past(gain_idx)) |->
      ((gain_idx == $past(gain_idx) + 1'b1) || (gain_idx + 1'b1 == $past(gain_idx)))); // R3

  AST_CHG_MATCH: assert property (@(posedge clk) disable iff (!rst_s2)
    gain_chg == (gain_idx != $past(gain_idx))); // R3

  AST_NO_CHG_UNUSABLE: assert property (@(posedge clk) disable iff (!rst_s2)
    !smp_ok |=> !gain_chg); // R2

  AST_STABLE_CLR: assert property (@(posedge clk) disable iff (!rst_s2)
    gain_chg |-> !range_stable); // R9

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_s2)
    (gain_idx == MAX_IDX) |-> ($past(gain_idx) != '0)); // R8

endmodule

// File: tb/arc_top_tb.sv
module arc_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAG_W = 16;
  localparam int NR    = 8;
  localparam int NVEC  = 31;

  logic              clk;
  logic              rst_n;
  logic              smp_valid;
  logic [MAG_W-1:0]  smp_mag;
  logic              smp_clip;
  logic [NR*MAG_W-1:0] thr_hi;
  logic [NR*MAG_W-1:0] thr_lo;
  logic [7:0]        dwell_len, blank_len, run_len;
  logic [2:0]        gain_idx;
  logic              gain_chg, range_stable, smp_ok;

  int checks = 0;
  int errors = 0;

  arc_top u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_valid    (smp_valid),
    .smp_mag      (smp_mag),
    .smp_clip     (smp_clip),
    .thr_hi       (thr_hi),
    .thr_lo       (thr_lo),
    .dwell_len    (dwell_len),
    .blank_len    (blank_len),
    .run_len      (run_len),
    .gain_idx     (gain_idx),
    .gain_chg     (gain_chg),
    .range_stable (range_stable),
    .smp_ok       (smp_ok)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // vector: {valid, clip, mag[15:0], exp_ok, exp_idx[2:0], exp_chg, exp_stable}
  // config: dwell 3, blank 2, run 3, lower 12000, upper 48000 - r*1000
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 16'd20000, 1'b1, 3'd0, 1'b0, 1'b1}, // 0  in window, R9
    {1'b1, 1'b0, 16'd5000,  1'b1, 3'd0, 1'b0, 1'b1}, // 1  quiet 1, R7
    {1'b1, 1'b0, 16'd5000,  1'b1, 3'd0, 1'b0, 1'b1}, // 2  quiet 2
    {1'b1, 1'b0, 16'd5000,  1'b1, 3'd1, 1'b1, 1'b0}, // 3  quiet 3 -> up, R6
    {1'b1, 1'b0, 16'd5000,  1'b0, 3'd1, 1'b0, 1'b0}, // 4  blanked, R2
    {1'b1, 1'b0, 16'd60000, 1'b0, 3'd1, 1'b0, 1'b0}, // 5  blanked over-threshold ignored, R2
    {1'b1, 1'b0, 16'd5000,  1'b1, 3'd1, 1'b0, 1'b0}, // 6  quiet fails confirm, R9
    {1'b1, 1'b0, 16'd20000, 1'b1, 3'd1, 1'b0, 1'b1}, // 7  confirm, R9
    {1'b1, 1'b0, 16'd60000, 1'b1, 3'd0, 1'b1, 1'b0}, // 8  single over -> down, R5 R7
    {1'b1, 1'b1, 16'd20000, 1'b0, 3'd0, 1'b0, 1'b0}, // 9  clip blanked, R2
    {1'b1, 1'b0, 16'd20000, 1'b0, 3'd0, 1'b0, 1'b0}, // 10 blanked
    {1'b1, 1'b0, 16'd20000, 1'b1, 3'd0, 1'b0, 1'b1}, // 11 confirm
    {1'b1, 1'b0, 16'd5000,  1'b1, 3'd0, 1'b0, 1'b1}, // 12
    {1'b1, 1'b0, 16'd5000,  1'b1, 3'd0, 1'b0, 1'b1}, // 13
    {1'b1, 1'b0, 16'd5000,  1'b1, 3'd1, 1'b1, 1'b0}, // 14 up, R6
    {1'b1, 1'b0, 16'd20000, 1'b0, 3'd1, 1'b0, 1'b0}, // 15 blanked
    {1'b1, 1'b0, 16'd20000, 1'b0, 3'd1, 1'b0, 1'b0}, // 16 blanked
    {1'b1, 1'b1, 16'd20000, 1'b1, 3'd0, 1'b1, 1'b0}, // 17 clip inside dwell -> down, R4
    {1'b1, 1'b0, 16'd20000, 1'b0, 3'd0, 1'b0, 1'b0}, // 18 blanked
    {1'b1, 1'b0, 16'd20000, 1'b0, 3'd0, 1'b0, 1'b0}, // 19 blanked
    {1'b1, 1'b0, 16'd5000,  1'b1, 3'd0, 1'b0, 1'b0}, // 20
    {1'b1, 1'b0, 16'd5000,  1'b1, 3'd0, 1'b0, 1'b0}, // 21
    {1'b1, 1'b0, 16'd5000,  1'b1, 3'd1, 1'b1, 1'b0}, // 22 up
    {1'b1, 1'b0, 16'd20000, 1'b0, 3'd1, 1'b0, 1'b0}, // 23 blanked
    {1'b1, 1'b0, 16'd20000, 1'b0, 3'd1, 1'b0, 1'b0}, // 24 blanked
    {1'b1, 1'b0, 16'd47500, 1'b1, 3'd1, 1'b0, 1'b0}, // 25 over range 1 only, dwell blocks, R5 R10
    {1'b1, 1'b0, 16'd47500, 1'b1, 3'd0, 1'b1, 1'b0}, // 26 dwell met -> down, R5
    {1'b0, 1'b1, 16'd5000,  1'b0, 3'd0, 1'b0, 1'b0}, // 27 no strobe, R2
    {1'b1, 1'b0, 16'd20000, 1'b0, 3'd0, 1'b0, 1'b0}, // 28 blanked
    {1'b1, 1'b0, 16'd20000, 1'b0, 3'd0, 1'b0, 1'b0}, // 29 blanked
    {1'b1, 1'b0, 16'd20000, 1'b1, 3'd0, 1'b0, 1'b1}  // 30 confirm
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] dw, input logic [7:0] bl, input logic [7:0] rl);
    @(negedge clk);
    rst_n     = 1'b0;
    smp_valid = 1'b0;
    smp_clip  = 1'b0;
    smp_mag   = '0;
    dwell_len = dw;
    blank_len = bl;
    run_len   = rl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic sample(input logic v, input logic c, input logic [15:0] m,
                        input logic e_ok, input int e_idx, input logic e_chg,
                        input logic e_st, input string tag);
    @(negedge clk);
    smp_valid = v;
    smp_clip  = c;
    smp_mag   = m;
    #1;
    check({tag, " R2 smp_ok"}, int'(smp_ok), int'(e_ok));
    @(posedge clk);
    #1;
    check({tag, " R3 gain_idx"}, int'(gain_idx), e_idx);
    check({tag, " R3 gain_chg"}, int'(gain_chg), int'(e_chg));
    check({tag, " R9 range_stable"}, int'(range_stable), int'(e_st));
    smp_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    smp_valid = 1'b0;
    smp_clip  = 1'b0;
    smp_mag   = '0;
    dwell_len = 8'd3;
    blank_len = 8'd2;
    run_len   = 8'd3;
    for (int r = 0; r < NR; r++) begin
      thr_hi[r*MAG_W +: MAG_W] = 16'(48000 - r * 1000);
      thr_lo[r*MAG_W +: MAG_W] = 16'd12000;
    end

    // R1: values during reset
    repeat (2) @(negedge clk);
    check("R1 idx in reset", int'(gain_idx), 0);
    check("R1 chg in reset", int'(gain_chg), 0);
    check("R1 stable in reset", int'(range_stable), 0);

    do_reset(8'd3, 8'd2, 8'd3);
    check("R1 idx after release", int'(gain_idx), 0);
    check("R1 stable after release", int'(range_stable), 0);
    check("R1 chg after release", int'(gain_chg), 0);

    for (int i = 0; i < NVEC; i++) begin
      sample(VEC[i][23], VEC[i][22], VEC[i][21:6], VEC[i][5],
             int'(VEC[i][4:2]), VEC[i][1], VEC[i][0], $sformatf("vec %0d", i));
    end

    // R8: no downshift below range 0, for clip and for over-threshold
    do_reset(8'd0, 8'd0, 8'd3);
    sample(1'b1, 1'b1, 16'd60000, 1'b1, 0, 1'b0, 1'b0, "R8 clip at bottom");
    sample(1'b1, 1'b0, 16'd60000, 1'b1, 0, 1'b0, 1'b0, "R8 over at bottom");

    // R8 and R6: climb to the top with run 1, then hold
    do_reset(8'd0, 8'd0, 8'd1);
    for (int s = 1; s <= 7; s++) begin
      sample(1'b1, 1'b0, 16'd100, 1'b1, s, 1'b1, 1'b0, "R6 climb");
    end
    sample(1'b1, 1'b0, 16'd100, 1'b1, 7, 1'b0, 1'b0, "R8 top hold");
    sample(1'b1, 1'b0, 16'd100, 1'b1, 7, 1'b0, 1'b0, "R8 top hold again");

    // R5 and R6: run 0 acts as 1, but dwell 4 holds the upshift back
    do_reset(8'd4, 8'd0, 8'd0);
    for (int s = 0; s < 4; s++) begin
      sample(1'b1, 1'b0, 16'd100, 1'b1, 0, 1'b0, 1'b0, "R6 dwell lockout");
    end
    sample(1'b1, 1'b0, 16'd100, 1'b1, 1, 1'b1, 1'b0, "R6 dwell met");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule